// File: doc/BRIEF.md
# Ping-Pong Bitstream Buffer Manager

This block arbitrates a two-bank bitstream store placed between an entropy coder and a DMA engine. A 3-bit mode input chooses between static attachment and automatic alternation. In the static modes each bank is tied to the coprocessor bus, the DMA port or the coder port, and the block issues no DMA work. In the two automatic modes (encode and decode) the banks trade places between the coder and the DMA. The block tracks which bank each side owns and raises sized DMA requests on a selectable synchronisation line.

In encode, the coder writes one bank while the DMA empties the other. A bank that the coder reports as full goes to the DMA as soon as the DMA has emptied its previous bank. An end-of-stream event from the coder causes the partly written bank to be drained as well. Busy drops once nothing is left to move. In decode, the DMA loads a bank ahead of the coder. A bank goes back to the DMA for refilling once the coder reports it consumed. Busy stays high until the mode leaves automatic operation.

Each bank holds 2048 bytes. Bank 0 is the lower window and bank 1 the upper window of each port's address space, so a port decodes the bank from its top address bit.

Top module: `bsb_pingpong`

## Requirements
- R1: One cycle after a mode value is presented, the bank selects follow it. The select codes are 0 = coprocessor bus, 1 = DMA, 2 = coder. The mode values map as follows:
  - mode 0: both banks select 0.
  - mode 1: both banks select 1.
  - mode 2: both banks select 2.
  - mode 3: bank 0 selects 1 and bank 1 selects 2.
  - mode 4: bank 0 selects 2 and bank 1 selects 1.
  - mode 7: behaves as mode 0.
- R2: In modes 0 to 4 and 7, every DMA request line and busy stay 0, whatever coder and DMA events arrive.
- R3: After reset, both selects read 0, busy reads 0 and no request is raised.
- R4: Encode is mode 5. On entry, busy reads 1, the coder owns bank 0 and the DMA owns bank 1, with no request. A coder-full pulse while the DMA is idle swaps the banks on the next edge and starts draining the full bank.
- R5: A coder-full pulse that arrives while the DMA is still draining is held. The swap then occurs on the same edge that accepts the last chunk of the drain.
- R6: Size field value s gives 2^s requests per bank, each of 2048>>s bytes (0 = 2048, 1 = 1024, 2 = 512, 3 = 256), and dma_bytes_o reports that size. The size is captured when a bank's transfer starts, and later changes do not affect that bank.
- R7: The request is raised only on line sync_chan_i of dma_req_o. It drops for one cycle after each accepted done pulse. A done pulse while the request is low is ignored.
- R8: An end-of-stream pulse in encode queues the partly written bank for draining. Busy falls on the edge that accepts the last chunk once no bank remains, and later coder events are ignored.
- R9: Decode is mode 6. On entry, busy reads 1, the DMA fills bank 0 and the coder owns bank 1. The banks swap when the fill completes and the coder has released its bank; the first release is implicit and later releases come from coder-empty pulses.
- R10: In decode, busy stays 1 while the mode is held, and end-of-stream pulses have no effect.
- R11: Any change of mode discards the automatic state. Entering an automatic mode, including directly from the other automatic mode, restarts it from its entry state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Buffer operating mode |
| xfer_size_i | input | 2 | Per-request transfer size code |
| sync_chan_i | input | 2 | DMA sync line used for requests |
| coder_full_i | input | 1 | Coder has filled its bank (encode) |
| coder_empty_i | input | 1 | Coder has consumed its bank (decode) |
| coder_last_i | input | 1 | Coder reached end of stream (encode) |
| dma_done_i | input | 1 | DMA finished the current request |
| bank0_sel_o | output | 2 | Owner of bank 0 |
| bank1_sel_o | output | 2 | Owner of bank 1 |
| dma_req_o | output | 4 | Request, one line per sync channel |
| dma_bank_o | output | 1 | Bank targeted by the DMA |
| dma_bytes_o | output | 12 | Bytes moved by the pending request |
| busy_o | output | 1 | Automatic operation in progress |

## Verification
The bench raises coder-full while the DMA is mid-drain. A design that swaps at once would hand the DMA a bank still being drained; one that drops the pulse would stall forever. It feeds a done pulse during the one-cycle request gap, which a design that counts it would use to end the bank a chunk early. It changes the size field mid-bank, where a design that does not capture the size would report the new byte count. It also covers the flush after end-of-stream, where an early busy drop would leave a partial bank in the buffer, and the direct switch between encode and decode, where stale ownership would misroute the first bank.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

    localparam int MODE_W = 3;
    localparam int SIZE_W = 2;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        RT_COPR  = 2'd0,
        RT_DMA   = 2'd1,
        RT_CODER = 2'd2
    } route_e;

    localparam logic [MODE_W-1:0] MODE_ENC = 3'd5;
    localparam logic [MODE_W-1:0] MODE_DEC = 3'd6;

    function automatic logic is_auto(input logic [MODE_W-1:0] m);
        return (m == MODE_ENC) || (m == MODE_DEC);
    endfunction

endpackage

// File: rtl/bsb_route.sv
module bsb_route
    import bsb_pkg::*;
(
    input  logic [MODE_W-1:0]           mode_i,
    input  logic                        cb_i,
    output logic [1:0][SEL_W-1:0]       sel_o
);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic ME = 1'(b);
        route_e r;

        always_comb begin
            case (mode_i)
                3'd1:    r = RT_DMA;
                3'd2:    r = RT_CODER;
                3'd3:    r = ME ? RT_CODER : RT_DMA;
                3'd4:    r = ME ? RT_DMA : RT_CODER;
                3'd5,
                3'd6:    r = (cb_i == ME) ? RT_CODER : RT_DMA;
                default: r = RT_COPR;
            endcase
        end

        assign sel_o[b] = r;
    end

endmodule

// File: rtl/bsb_xfer.sv
module bsb_xfer
    import bsb_pkg::*;
#(
    parameter int BANK_BYTES = 2048
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 start_i,
    input  logic [SIZE_W-1:0]    size_i,
    input  logic                 done_i,
    output logic                 work_o,
    output logic                 fin_o,
    output logic                 req_o,
    output logic [$clog2(BANK_BYTES):0] bytes_o
);

    localparam int CNT_W   = 2 ** SIZE_W;
    localparam int BYTES_W = $clog2(BANK_BYTES) + 1;

    typedef struct packed {
        logic              work;
        logic              gap;
        logic [CNT_W-1:0]  left;
        logic [SIZE_W-1:0] size;
    } xfer_t;

    xfer_t xfer_d, xfer_q;
    logic  take;

    assign take  = xfer_q.work && !xfer_q.gap && done_i;
    assign fin_o = take && (xfer_q.left == CNT_W'(1));

    always_comb begin
        xfer_d = xfer_q;
        if (start_i) begin
            xfer_d.work = 1'b1;
            xfer_d.gap  = 1'b0;
            xfer_d.left = CNT_W'(1) << size_i;
            xfer_d.size = size_i;
        end else if (clear_i) begin
            xfer_d = '0;
        end else begin
            xfer_d.gap = 1'b0;
            if (fin_o) begin
                xfer_d.work = 1'b0;
            end else if (take) begin
                xfer_d.left = xfer_q.left - CNT_W'(1);
                xfer_d.gap  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xfer_q <= '0;
        else        xfer_q <= xfer_d;
    end

    assign work_o  = xfer_q.work;
    assign req_o   = xfer_q.work && !xfer_q.gap;
    assign bytes_o = xfer_q.work ? (BYTES_W'(BANK_BYTES) >> xfer_q.size) : '0;

endmodule

// File: rtl/bsb_seq.sv
module bsb_seq
    import bsb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               coder_full_i,
    input  logic               coder_empty_i,
    input  logic               coder_last_i,
    input  logic               xfer_work_i,
    input  logic               xfer_fin_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic               cb_o,
    output logic               busy_o,
    output logic               start_o,
    output logic               clear_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              cb;
        logic              hand;
        logic              ending;
        logic              busy;
    } seq_t;

    seq_t seq_d, seq_q;
    logic chg, enc, run, ev, hand_a, end_a, dma_idle;

    always_comb begin
        seq_d    = seq_q;
        seq_d.mode = mode_i;
        start_o  = 1'b0;
        clear_o  = 1'b0;
        chg      = (mode_i != seq_q.mode);
        enc      = (seq_q.mode == MODE_ENC);
        run      = !chg && is_auto(seq_q.mode) && seq_q.busy;
        ev       = enc ? (coder_full_i | coder_last_i) : coder_empty_i;
        hand_a   = seq_q.hand | (run && !seq_q.ending && ev);
        end_a    = seq_q.ending | (run && enc && coder_last_i);
        dma_idle = !xfer_work_i || xfer_fin_i;

        if (chg) begin
            clear_o      = 1'b1;
            seq_d.cb     = 1'b0;
            seq_d.hand   = 1'b0;
            seq_d.ending = 1'b0;
            seq_d.busy   = is_auto(mode_i);
            if (mode_i == MODE_DEC) begin
                seq_d.cb   = 1'b1;
                seq_d.hand = 1'b1;
                start_o    = 1'b1;
            end
        end else if (run) begin
            seq_d.hand   = hand_a;
            seq_d.ending = end_a;
            if (hand_a && dma_idle) begin
                seq_d.cb   = ~seq_q.cb;
                seq_d.hand = 1'b0;
                start_o    = 1'b1;
            end else if (enc && end_a && !hand_a && dma_idle) begin
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign mode_o = seq_q.mode;
    assign cb_o   = seq_q.cb;
    assign busy_o = seq_q.busy;

endmodule

// File: rtl/bsb_pingpong.sv
module bsb_pingpong
    import bsb_pkg::*;
#(
    parameter int BANK_BYTES = 2048,
    parameter int NUM_CHAN   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    mode_i,
    input  logic [1:0]                    xfer_size_i,
    input  logic [$clog2(NUM_CHAN)-1:0]   sync_chan_i,
    input  logic                          coder_full_i,
    input  logic                          coder_empty_i,
    input  logic                          coder_last_i,
    input  logic                          dma_done_i,
    output logic [1:0]                    bank0_sel_o,
    output logic [1:0]                    bank1_sel_o,
    output logic [NUM_CHAN-1:0]           dma_req_o,
    output logic                          dma_bank_o,
    output logic [$clog2(BANK_BYTES):0]   dma_bytes_o,
    output logic                          busy_o
);

    localparam int CH_W    = $clog2(NUM_CHAN);
    localparam int BYTES_W = $clog2(BANK_BYTES) + 1;

    logic [MODE_W-1:0]     mode_q;
    logic                  cb;
    logic                  start;
    logic                  clear;
    logic                  xfer_work;
    logic                  xfer_fin;
    logic                  req_on;
    logic [1:0][SEL_W-1:0] sel;

    bsb_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .coder_full_i (coder_full_i),
        .coder_empty_i(coder_empty_i),
        .coder_last_i (coder_last_i),
        .xfer_work_i  (xfer_work),
        .xfer_fin_i   (xfer_fin),
        .mode_o       (mode_q),
        .cb_o         (cb),
        .busy_o       (busy_o),
        .start_o      (start),
        .clear_o      (clear)
    );

    bsb_xfer #(.BANK_BYTES(BANK_BYTES)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .start_i (start),
        .size_i  (xfer_size_i),
        .done_i  (dma_done_i),
        .work_o  (xfer_work),
        .fin_o   (xfer_fin),
        .req_o   (req_on),
        .bytes_o (dma_bytes_o)
    );

    bsb_route u_route (
        .mode_i (mode_q),
        .cb_i   (cb),
        .sel_o  (sel)
    );

    assign bank0_sel_o = sel[0];
    assign bank1_sel_o = sel[1];
    assign dma_bank_o  = is_auto(mode_q) ? ~cb : 1'b0;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_req
        assign dma_req_o[c] = req_on && (sync_chan_i == CH_W'(c));
    end

endmodule

// File: rtl/bsb_pingpong_chk.sv
module bsb_pingpong_chk
    import bsb_pkg::*;
#(
    parameter int NUM_CHAN = 4,
    parameter int BYTES_W  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          mode_i,
    input logic                dma_done_i,
    input logic [1:0]          bank0_sel_o,
    input logic [1:0]          bank1_sel_o,
    input logic [NUM_CHAN-1:0] dma_req_o,
    input logic                dma_bank_o,
    input logic [BYTES_W-1:0]  dma_bytes_o,
    input logic                busy_o
);

    AST_REQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dma_req_o)); // R7

    AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !is_auto(mode_i) |=> (dma_req_o == '0) && !busy_o); // R2

    AST_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_auto(mode_i) && !$stable(mode_i)) |=> busy_o); // R11

    AST_AUTO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_auto(mode_i) |=> ((bank0_sel_o == RT_CODER && bank1_sel_o == RT_DMA) ||
                             (bank0_sel_o == RT_DMA && bank1_sel_o == RT_CODER))); // R4

    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dma_req_o) && dma_done_i && $stable(mode_i)) |=>
        ((dma_req_o == '0) || (dma_bank_o != $past(dma_bank_o)))); // R7

    AST_BYTES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_req_o) |-> ($countones(dma_bytes_o) == 1)); // R6

endmodule

bind bsb_pingpong bsb_pingpong_chk #(
    .NUM_CHAN (NUM_CHAN),
    .BYTES_W  (BYTES_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .dma_done_i  (dma_done_i),
    .bank0_sel_o (bank0_sel_o),
    .bank1_sel_o (bank1_sel_o),
    .dma_req_o   (dma_req_o),
    .dma_bank_o  (dma_bank_o),
    .dma_bytes_o (dma_bytes_o),
    .busy_o      (busy_o)
);

// File: tb/bsb_pingpong_bench.sv
`timescale 1ns/1ps
module bsb_pingpong_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [1:0]  size = 2'd0;
    logic [1:0]  chan = 2'd0;
    logic        full = 1'b0, empty = 1'b0, last = 1'b0, done = 1'b0;
    logic [1:0]  b0, b1;
    logic [3:0]  req;
    logic        bank, busy;
    logic [11:0] bytes;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bsb_pingpong u_bsb_pingpong (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .xfer_size_i(size), .sync_chan_i(chan),
        .coder_full_i(full), .coder_empty_i(empty), .coder_last_i(last), .dma_done_i(done),
        .bank0_sel_o(b0), .bank1_sel_o(b1), .dma_req_o(req), .dma_bank_o(bank),
        .dma_bytes_o(bytes), .busy_o(busy)
    );

    function automatic logic [1:0] exp_sel(input logic [2:0] m, input int b);
        case (m)
            3'd1:    return 2'd1;
            3'd2:    return 2'd2;
            3'd3:    return (b == 0) ? 2'd1 : 2'd2;
            3'd4:    return (b == 0) ? 2'd2 : 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            done = 1'b1; step(); done = 1'b0; step();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R3 reset sel0", b0, 0); chk("R3 reset sel1", b1, 0);
        chk("R3 reset req", req, 0); chk("R3 reset busy", busy, 0);
        rst_n = 1'b1;
        step();

        // Directed manual modes
        for (int k = 0; k < 6; k++) begin
            mode = (k == 5) ? 3'd7 : 3'(k);
            step();
            chk("R1 sel0", b0, exp_sel(mode, 0));
            chk("R1 sel1", b1, exp_sel(mode, 1));
        end

        // Random manual modes with random events
        for (int k = 0; k < 200; k++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 5));
            mode = (m == 3'd5) ? 3'd7 : m;
            full = 1'($urandom); empty = 1'($urandom); last = 1'($urandom); done = 1'($urandom);
            size = 2'($urandom); chan = 2'($urandom);
            step();
            chk("R1 rnd sel0", b0, exp_sel(mode, 0));
            chk("R1 rnd sel1", b1, exp_sel(mode, 1));
            chk("R2 rnd req", req, 0);
            chk("R2 rnd busy", busy, 0);
        end
        full = 0; empty = 0; last = 0; done = 0;

        // Encode
        chan = 2'd2; size = 2'd2;
        mode = 3'd5; step();
        chk("R4 entry sel0", b0, 2); chk("R4 entry sel1", b1, 1);
        chk("R4 entry req", req, 0); chk("R4 entry busy", busy, 1);
        full = 1; step(); full = 0;
        chk("R4 swap sel0", b0, 1); chk("R4 swap sel1", b1, 2);
        chk("R7 req line", req, 4'b0100); chk("R4 dma bank", bank, 0);
        chk("R6 bytes 512", bytes, 512);
        done = 1; step(); done = 0;
        chk("R7 gap", req, 0);
        done = 1; step(); done = 0;
        chk("R7 done in gap ignored", req, 4'b0100);
        drain(2);
        full = 1; step(); full = 0;
        chk("R5 held sel0", b0, 1); chk("R5 held sel1", b1, 2);
        done = 1; step(); done = 0;
        chk("R5 swap on last chunk sel0", b0, 2); chk("R5 swap bank", bank, 1);
        chk("R5 req continues", req, 4'b0100);
        last = 1; step(); last = 0;
        chk("R8 busy after last", busy, 1);
        drain(4);
        chk("R8 partial bank drained sel0", b0, 1); chk("R8 partial bank", bank, 0);
        chk("R8 busy during flush", busy, 1);
        size = 2'd0; step();
        chk("R6 size latched", bytes, 512);
        drain(4);
        chk("R8 busy cleared", busy, 0); chk("R8 req idle", req, 0);
        full = 1; step(); full = 0;
        chk("R8 later full ignored req", req, 0); chk("R8 later full busy", busy, 0);

        // Decode
        mode = 3'd0; step();
        chan = 2'd1; size = 2'd1;
        mode = 3'd6; step();
        chk("R9 entry sel0", b0, 1); chk("R9 entry sel1", b1, 2);
        chk("R9 entry req", req, 4'b0010); chk("R9 entry bank", bank, 0);
        chk("R6 bytes 1024", bytes, 1024); chk("R9 entry busy", busy, 1);
        drain(2);
        chk("R9 swap sel0", b0, 2); chk("R9 swap bank", bank, 1);
        chk("R9 refill req", req, 4'b0010);
        size = 2'd3;
        drain(2);
        chk("R9 waits for release", req, 0); chk("R9 wait sel0", b0, 2);
        last = 1; step(); last = 0;
        chk("R10 last ignored busy", busy, 1); chk("R10 last ignored req", req, 0);
        empty = 1; step(); empty = 0;
        chk("R9 release swap sel0", b0, 1); chk("R9 release bank", bank, 0);
        chk("R6 bytes 256", bytes, 256); chk("R9 release req", req, 4'b0010);
        drain(7);
        chk("R6 eight chunks pending", req, 4'b0010);
        drain(1);
        chk("R6 eight chunks done", req, 0);
        chk("R10 busy held", busy, 1);

        // Mode switching
        mode = 3'd5; step();
        chk("R11 to encode sel0", b0, 2); chk("R11 to encode req", req, 0);
        chk("R11 to encode busy", busy, 1);
        mode = 3'd6; step();
        chk("R11 to decode sel0", b0, 1); chk("R11 to decode req", req, 4'b0010);
        mode = 3'd3; step();
        chk("R11 to manual sel0", b0, 1); chk("R11 to manual sel1", b1, 2);
        chk("R11 to manual busy", busy, 0); chk("R11 to manual req", req, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule